// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the pin-side scan register of a test access path. It places one scan cell behind every digital pin of a device and links the cells into a single serial shift register between a scan input and a scan output. A test access controller (not part of this block) drives four control levels: a capture strobe, a shift enable, an update strobe and a test-mode select that is high while the external-test instruction is active and low under the sample/preload instruction.

Input pins get one cell each, which records the level on the pin. Output pins get two cells each: one for the data level and one for the output enable. Both have a shift stage and a separate holding stage. The holding stage keeps its value while new bits shift through the chain. This allows a safe sequence: preload a pattern in sample mode, latch it into the holding stages, and only then switch to test mode, so the pins go straight to the preloaded values with no shift-time glitches. Setting an enable cell to 0 before the mode switch puts that pin in high impedance.

Top module: `bsr_chain`

## Requirements
- R1: While rst_n is low at a clock edge, every shift stage is cleared on the rising edge and every holding stage is cleared on the falling edge. With test mode selected after reset, pad_out and pad_oe are all 0.
- R2: The chain holds NUM_IN + 2*NUM_OUT cells. Cells 0 to NUM_IN-1 belong to pad_in bits 0 to NUM_IN-1. Cell NUM_IN+2k is the data cell and cell NUM_IN+2k+1 is the enable cell of output pin k.
- R3: On a rising tck edge with shift_en high and cap_en low, every cell takes the value of the cell above it. Cell CHAIN_LEN-1 takes scan_in. scan_out always shows cell 0, so a vector shifted in bit 0 first ends with bit j in cell j.
- R4: On a rising tck edge with cap_en high, all cells load their parallel value at once: an input cell loads its pad_in bit, a data cell loads its pad_out bit and an enable cell loads its pad_oe bit. Capture wins over shift.
- R5: On a falling tck edge with upd_en high, the holding stages of the output-pin cells copy their shift stages. At any other time they keep their value, including during shift and capture.
- R6: With test_mode low, pad_out equals core_out and pad_oe equals core_oe, whatever the holding stages contain.
- R7: With test_mode high, pad_out and pad_oe come from the data and enable holding stages. They do not change while bits are shifted or captured without an update.
- R8: core_in always equals pad_in in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_in | input | 1 | Serial data into the top cell |
| scan_out | output | 1 | Serial data from cell 0 |
| cap_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift enable |
| upd_en | input | 1 | Holding-stage update strobe (falling edge) |
| test_mode | input | 1 | 1: pins driven by chain, 0: pins driven by core |
| core_out | input | NUM_OUT | Core-side output data |
| core_oe | input | NUM_OUT | Core-side output enables |
| pad_out | output | NUM_OUT | Data to output pins |
| pad_oe | output | NUM_OUT | Enables to output pins |
| pad_in | input | NUM_IN | Levels from input pins |
| core_in | output | NUM_IN | Input pin levels passed to the core |

## Verification
The bench builds the chain with NUM_IN=3 and NUM_OUT=4, which gives an 11-cell chain. That is long enough to exercise both cell kinds, the interleaved data/enable order and a full scan of every cell in a few cycles. Random mixes of the two modes, captures, scans and updates are checked against a chain model held in the bench. Directed runs cover the full preload-then-switch sequence, a high-impedance preload, input capture in test mode and capture taking priority over shift.

// File: rtl/bsr_pkg.sv
// Package: shared cell classification for the boundary scan chain.
// Assumes cells are numbered from the scan-output end.
package bsr_pkg;

    typedef enum logic [1:0] {
        CELL_INPUT  = 2'd0,
        CELL_DATA   = 2'd1,
        CELL_ENABLE = 2'd2
    } cell_kind_e;

    // Length of a chain for the given pin counts.
    function automatic int unsigned chain_len(input int unsigned n_in, input int unsigned n_out);
        return n_in + 2 * n_out;
    endfunction

    // Kind of cell at a chain position.
    function automatic cell_kind_e cell_kind(input int unsigned idx, input int unsigned n_in);
        if (idx < n_in)
            return CELL_INPUT;
        else if (((idx - n_in) % 2) == 0)
            return CELL_DATA;
        else
            return CELL_ENABLE;
    endfunction

endpackage

// File: rtl/bsr_shift_stage.sv
// Module: one shift-stage flop of a scan cell.
// On the rising edge it loads its parallel value when capturing, or the
// bit from the next cell up when shifting. Capture has priority.
// Assumes rst_n is synchronous to tck.
module bsr_shift_stage (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic par_in,
    input  logic ser_in,
    output logic q
);

    // Shift-stage register: reset, capture, shift or hold.
    always_ff @(posedge tck) begin
        if (!rst_n)
            q <= 1'b0;
        else if (cap_en)
            q <= par_in;
        else if (shift_en)
            q <= ser_in;
    end

endmodule

// File: rtl/bsr_hold_stage.sv
// Module: holding stages of all output-pin cells, updated on the falling
// edge of tck. Kept apart from the shift stages so that shifting never
// disturbs the values presented to the pins.
// Assumes upd_en is stable around the falling edge.
module bsr_hold_stage #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Holding register: cleared by reset, loaded only while updating.
    always_ff @(negedge tck) begin
        if (!rst_n)
            q <= '0;
        else if (upd_en)
            q <= d;
    end

endmodule

// File: rtl/bsr_pad_mux.sv
// Module: per-output-pin selection between core and holding stage.
// Assumes test_mode is decoded from the active instruction upstream.
module bsr_pad_mux (
    input  logic test_mode,
    input  logic core_d,
    input  logic core_e,
    input  logic hold_d,
    input  logic hold_e,
    output logic pad_d,
    output logic pad_e
);

    // Pin source select: the chain owns the pin in test mode.
    always_comb begin
        if (test_mode) begin
            pad_d = hold_d;
            pad_e = hold_e;
        end else begin
            pad_d = core_d;
            pad_e = core_e;
        end
    end

endmodule

// File: rtl/bsr_chain.sv
// Module: boundary scan register chain (top).
// Input cells come first from the scan-output end, then a data cell and an
// enable cell for each output pin. Shift stages move on the rising edge,
// holding stages update on the falling edge.
// Assumes the control levels come from a test access controller on tck.
module bsr_chain #(
    parameter int unsigned NUM_IN  = 3,
    parameter int unsigned NUM_OUT = 4
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               scan_in,
    output logic               scan_out,
    input  logic               cap_en,
    input  logic               shift_en,
    input  logic               upd_en,
    input  logic               test_mode,
    input  logic [NUM_OUT-1:0] core_out,
    input  logic [NUM_OUT-1:0] core_oe,
    output logic [NUM_OUT-1:0] pad_out,
    output logic [NUM_OUT-1:0] pad_oe,
    input  logic [NUM_IN-1:0]  pad_in,
    output logic [NUM_IN-1:0]  core_in
);
    import bsr_pkg::*;

    localparam int unsigned CHAIN_LEN = chain_len(NUM_IN, NUM_OUT);
    localparam int unsigned HOLD_W    = 2 * NUM_OUT;

    logic [CHAIN_LEN-1:0] sh_q;
    logic [CHAIN_LEN-1:0] ser_nxt;
    logic [CHAIN_LEN-1:0] cap_val;
    logic [HOLD_W-1:0]    hold_q;

    // Serial source of each cell: the cell above, or scan_in at the top.
    assign ser_nxt  = {scan_in, sh_q[CHAIN_LEN-1:1]};
    assign scan_out = sh_q[0];
    assign core_in  = pad_in;

    genvar gi;
    generate
        for (gi = 0; gi < CHAIN_LEN; gi++) begin : g_cell
            // Parallel capture source chosen by the cell kind.
            if (cell_kind(gi, NUM_IN) == CELL_INPUT) begin : g_in
                assign cap_val[gi] = pad_in[gi];
            end else if (cell_kind(gi, NUM_IN) == CELL_DATA) begin : g_data
                assign cap_val[gi] = pad_out[(gi - NUM_IN) / 2];
            end else begin : g_en
                assign cap_val[gi] = pad_oe[(gi - NUM_IN) / 2];
            end

            bsr_shift_stage u_sh (
                .tck      (tck),
                .rst_n    (rst_n),
                .cap_en   (cap_en),
                .shift_en (shift_en),
                .par_in   (cap_val[gi]),
                .ser_in   (ser_nxt[gi]),
                .q        (sh_q[gi])
            );
        end

        for (gi = 0; gi < NUM_OUT; gi++) begin : g_pin
            bsr_pad_mux u_mux (
                .test_mode (test_mode),
                .core_d    (core_out[gi]),
                .core_e    (core_oe[gi]),
                .hold_d    (hold_q[2*gi]),
                .hold_e    (hold_q[2*gi+1]),
                .pad_d     (pad_out[gi]),
                .pad_e     (pad_oe[gi])
            );
        end
    endgenerate

    bsr_hold_stage #(.WIDTH(HOLD_W)) u_hold (
        .tck    (tck),
        .rst_n  (rst_n),
        .upd_en (upd_en),
        .d      (sh_q[CHAIN_LEN-1:NUM_IN]),
        .q      (hold_q)
    );

endmodule

// File: rtl/bsr_chain_chk.sv
// Checker: temporal properties of the scan chain, bound into bsr_chain.
module bsr_chain_chk #(
    parameter int unsigned CHAIN_LEN = 11,
    parameter int unsigned HOLD_W    = 8,
    parameter int unsigned NUM_OUT   = 4
) (
    input logic                 tck,
    input logic                 rst_n,
    input logic                 scan_in,
    input logic                 cap_en,
    input logic                 shift_en,
    input logic                 upd_en,
    input logic                 test_mode,
    input logic [CHAIN_LEN-1:0] sh_q,
    input logic [HOLD_W-1:0]    hold_q,
    input logic [NUM_OUT-1:0]   pad_out
);

    AST_SHIFT_MOVES: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_en && !cap_en) |=> (sh_q == {$past(scan_in), $past(sh_q[CHAIN_LEN-1:1])})); // R3

    AST_HOLD_KEPT: assert property (@(negedge tck) disable iff (!rst_n)
        !upd_en |=> $stable(hold_q)); // R5

    AST_HOLD_LOADS: assert property (@(negedge tck) disable iff (!rst_n)
        upd_en |=> (hold_q == $past(sh_q[CHAIN_LEN-1:CHAIN_LEN-HOLD_W]))); // R5

    AST_PINS_STEADY: assert property (@(negedge tck) disable iff (!rst_n)
        (test_mode && $past(test_mode) && !$past(upd_en)) |-> $stable(pad_out)); // R7

endmodule

bind bsr_chain bsr_chain_chk #(
    .CHAIN_LEN (CHAIN_LEN),
    .HOLD_W    (HOLD_W),
    .NUM_OUT   (NUM_OUT)
) u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .scan_in   (scan_in),
    .cap_en    (cap_en),
    .shift_en  (shift_en),
    .upd_en    (upd_en),
    .test_mode (test_mode),
    .sh_q      (sh_q),
    .hold_q    (hold_q),
    .pad_out   (pad_out)
);

// File: tb/bsr_chain_tb.sv
// Bench: random and directed stimulus against a chain model.
module bsr_chain_tb_top;
    localparam int NI = 3;
    localparam int NO = 4;
    localparam int L  = NI + 2 * NO;
    localparam int CLK_PERIOD = 10;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic scan_in = 1'b0, cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, test_mode = 1'b0;
    logic [NO-1:0] core_out = '0, core_oe = '0, pad_out, pad_oe;
    logic [NI-1:0] pad_in = '0, core_in;
    logic scan_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [2*NO-1:0] exp_hold = '0;

    bsr_chain #(.NUM_IN(NI), .NUM_OUT(NO)) dut_i (
        .tck(tck), .rst_n(rst_n), .scan_in(scan_in), .scan_out(scan_out),
        .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en), .test_mode(test_mode),
        .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_in(pad_in), .core_in(core_in)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Expected pin data from the mode and holding model (R6, R7).
    function automatic logic [NO-1:0] exp_pd(input logic m, input logic [2*NO-1:0] h, input logic [NO-1:0] c);
        logic [NO-1:0] r;
        for (int k = 0; k < NO; k++) r[k] = m ? h[2*k] : c[k];
        return r;
    endfunction

    function automatic logic [NO-1:0] exp_pe(input logic m, input logic [2*NO-1:0] h, input logic [NO-1:0] c);
        logic [NO-1:0] r;
        for (int k = 0; k < NO; k++) r[k] = m ? h[2*k+1] : c[k];
        return r;
    endfunction

    // Expected captured chain contents from the cell map (R2, R4).
    function automatic logic [L-1:0] exp_cap(input logic [NI-1:0] pi, input logic [NO-1:0] pd, input logic [NO-1:0] pe);
        logic [L-1:0] v;
        for (int i = 0; i < NI; i++) v[i] = pi[i];
        for (int k = 0; k < NO; k++) begin
            v[NI+2*k]   = pd[k];
            v[NI+2*k+1] = pe[k];
        end
        return v;
    endfunction

    task automatic tick();
        @(posedge tck);
        #2;
    endtask

    task automatic do_capture();
        cap_en = 1'b1;
        tick();
        cap_en = 1'b0;
    endtask

    // Full scan: vin bit 0 enters first; vout bit i is the old cell i.
    task automatic scan(input logic [L-1:0] vin, output logic [L-1:0] vout);
        shift_en = 1'b1;
        for (int i = 0; i < L; i++) begin
            scan_in = vin[i];
            vout[i] = scan_out;
            tick();
        end
        shift_en = 1'b0;
    endtask

    task automatic do_update(input logic [L-1:0] loaded);
        upd_en = 1'b1;
        @(negedge tck);
        #2;
        upd_en = 1'b0;
        exp_hold = loaded[L-1:NI];
        tick();
    endtask

    task automatic check_pins(input string req);
        check(pad_out == exp_pd(test_mode, exp_hold, core_out), req, pad_out, exp_pd(test_mode, exp_hold, core_out));
        check(pad_oe == exp_pe(test_mode, exp_hold, core_oe), req, pad_oe, exp_pe(test_mode, exp_hold, core_oe));
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] vin, vout, expv;
        void'($urandom(32'd4242));
        // R1: reset clears shift and holding stages even while shifting.
        shift_en = 1'b1;
        scan_in = 1'b1;
        repeat (4) tick();
        shift_en = 1'b0;
        rst_n = 1'b1;
        tick();
        test_mode = 1'b1;
        #1;
        check(pad_out == '0, "R1 pad_out after reset", pad_out, 0);
        check(pad_oe == '0, "R1 pad_oe after reset", pad_oe, 0);
        test_mode = 1'b0;
        scan('0, vout);
        check(vout == '0, "R1 chain clear after reset", vout, 0);

        // R4: capture wins over shift, map from R2.
        pad_in = 3'b101; core_out = 4'b0110; core_oe = 4'b1100;
        cap_en = 1'b1; shift_en = 1'b1; scan_in = 1'b1;
        tick();
        cap_en = 1'b0; shift_en = 1'b0;
        scan('0, vout);
        expv = exp_cap(pad_in, core_out, core_oe);
        check(vout == expv, "R4 capture over shift", vout, expv);

        // R5 R6: preload in sample mode leaves pins on the core.
        vin = exp_cap(3'b000, 4'b1010, 4'b0111);
        scan(vin, vout);
        do_update(vin);
        core_out = 4'b0101; core_oe = 4'b1111;
        #1;
        check_pins("R6 preload invisible");
        // R7: switch to test mode, preloaded values and high-Z enables appear.
        test_mode = 1'b1;
        #1;
        check(pad_out == 4'b1010, "R7 preload on pins", pad_out, 4'b1010);
        check(pad_oe == 4'b0111, "R7 enable preload gives high-Z on pin 3", pad_oe, 4'b0111);
        // R7 R5: shifting a new pattern in test mode leaves the pins steady.
        scan(exp_cap(3'b111, 4'b0001, 4'b0000), vout);
        check(pad_out == 4'b1010 && pad_oe == 4'b0111, "R7 pins steady during shift", {pad_out, pad_oe}, {4'b1010, 4'b0111});
        // R4 R8: input capture in test mode.
        pad_in = 3'b110;
        #1;
        check(core_in == pad_in, "R8 core_in follows pad_in", core_in, pad_in);
        do_capture();
        scan('0, vout);
        expv = exp_cap(3'b110, 4'b1010, 4'b0111);
        check(vout == expv, "R4 test-mode capture", vout, expv);
        test_mode = 1'b0;

        // Random mix of modes, captures, scans and updates.
        for (int it = 0; it < 80; it++) begin
            core_out = $urandom; core_oe = $urandom; pad_in = $urandom;
            test_mode = $urandom_range(0, 1);
            #1;
            check_pins("R6 R7 random pins");
            check(core_in == pad_in, "R8 random pass-through", core_in, pad_in);
            expv = exp_cap(pad_in, exp_pd(test_mode, exp_hold, core_out), exp_pe(test_mode, exp_hold, core_oe));
            do_capture();
            vin = L'($urandom);
            scan(vin, vout);
            check(vout == expv, "R3 R4 random capture scan", vout, expv);
            check_pins("R7 random pins after shift");
            if ($urandom_range(0, 1) == 1) begin
                do_update(vin);
                check_pins("R5 random after update");
            end
            scan(vin, vout);
            check(vout == vin, "R3 random shift-through", vout, vin);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule